// File: doc/BRIEF.md
# Character Display Host Register Port

This block is the microprocessor-facing side of a character display controller. The host drives a register-select line, a read/write line and an enable strobe, together with an 8-bit data bus. The select and direction lines together pick one of four operations: writing an instruction, reading status, writing a display byte or reading a display byte. Every operation takes effect on the falling edge of the enable strobe, seen through the block clock.

The block keeps a small display RAM, a 7-bit address counter and a data register that always holds a prefetched copy of the byte at the counter. A byte the host writes goes into RAM at the counter. The counter then steps, and the data register reloads from the new address. A byte the host reads is taken from the data register, after which the counter steps and the next byte is prefetched. Instruction and data writes start a busy period of fixed length. During that period the status byte shows the busy flag, and any further write or data read is dropped. The bus works 8 bits wide, or 4 bits wide on the upper four lines with two strobes for each byte.

Top module: `charlcd_host_port`

## Requirements
- R1: After reset the busy flag is 0, the address counter is 0x00, the bus is 8 bits wide, the counter steps upward, and the nibble phase expects a high nibble.
- R2: Select=0/dir=0 is an instruction write, select=0/dir=1 a status read, select=1/dir=0 a data write and select=1/dir=1 a data read. Data is taken from the bus as it stands when the enable strobe falls.
- R3: A status read returns the busy flag on bit 7 and the address counter on bits 6..0. It changes no state. The instruction register is never returned.
- R4: The instruction 1aaaaaaa loads the address counter with aaaaaaa and loads the data register with the RAM byte at that address.
- R5: A data write stores the byte at the address counter, steps the counter, and prefetches the byte at the new address into the data register.
- R6: A data read returns the data register, then steps the counter and prefetches the byte at the new address.
- R7: The instruction 000001d0 sets the step direction: d=1 counts up and d=0 counts down. The counter wraps modulo 128 in both directions.
- R8: The instruction 001wxxxx selects the bus width: w=1 for 8 bits and w=0 for 4 bits. The new width applies from the next transfer.
- R9: In 4-bit mode each byte takes two strobes on data lines 7..4, high nibble first. Reads present the high nibble and then the low nibble on lines 7..4, with lines 3..0 driven low.
- R10: An accepted instruction or data write holds the busy flag high for exactly BUSY_CYCLES clocks, starting with the clock edge that sees the strobe fall.
- R11: While busy, instruction writes, data writes and data reads are ignored. Status reads still work.
- R12: The bus output enable is high exactly while the enable strobe is high with the direction line set to read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Host enable strobe; the transfer is taken when it falls |
| rs_i | input | 1 | Register select: 0 instruction/status, 1 data |
| rw_i | input | 1 | Direction: 0 write, 1 read |
| db_i | input | 8 | Data from host (lines 7..4 only in 4-bit mode) |
| db_o | output | 8 | Read data toward the host |
| db_oe_o | output | 1 | Output enable for db_o |

## Verification
The state change caused by a transfer lands on the first clock edge where the registered strobe is high and the live strobe is low. The bench therefore releases the strobe at a falling clock edge and reads results only from the following falling edge onward. Read data is sampled one full clock after the strobe rises, while select and direction are held steady. The busy window is measured in edges counted from the capturing edge: a status read placed at edge 3 must show busy, and one placed at edge 4 must not, with BUSY_CYCLES set to 4. Writes issued back to back land their second strobe fall inside that window, so the ignored transfer is known to happen while busy.

// File: rtl/charlcd_pkg.sv
package charlcd_pkg;

   localparam int unsigned BUS_W = 8;
   localparam int unsigned NIB_W = 4;
   localparam int unsigned STAT_AW = 7;

   typedef enum logic [1:0] {
      OP_INSTR_WR  = 2'b00,
      OP_STATUS_RD = 2'b01,
      OP_DATA_WR   = 2'b10,
      OP_DATA_RD   = 2'b11
   } lcd_op_e;

   function automatic lcd_op_e op_of(input logic sel, input logic rd);
      return lcd_op_e'({sel, rd});
   endfunction

   function automatic logic is_set_addr(input logic [BUS_W-1:0] b);
      return b[7];
   endfunction

   function automatic logic is_width_set(input logic [BUS_W-1:0] b);
      return b[7:5] == 3'b001;
   endfunction

   function automatic logic is_step_set(input logic [BUS_W-1:0] b);
      return b[7:2] == 6'b000001;
   endfunction

endpackage

// File: rtl/charlcd_strobe.sv
module charlcd_strobe
   import charlcd_pkg::*;
#(
   parameter bit NARROW_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             rs_i,
   input  logic             rw_i,
   input  logic [BUS_W-1:0] db_i,
   input  logic             wide_i,
   output logic             xfer_v_o,
   output lcd_op_e          xfer_op_o,
   output logic [BUS_W-1:0] xfer_byte_o,
   output logic             phase_o
);

   logic en_q;
   logic fall;

   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en_i;
   end

   assign fall      = en_q & ~en_i;
   assign xfer_op_o = op_of(rs_i, rw_i);

   generate
      if (NARROW_EN) begin : g_narrow
         logic             phase_q;
         logic [NIB_W-1:0] hi_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               phase_q <= 1'b0;
               hi_q    <= '0;
            end else if (wide_i) begin
               phase_q <= 1'b0;
            end else if (fall) begin
               if (!phase_q) hi_q <= db_i[BUS_W-1 -: NIB_W];
               phase_q <= ~phase_q;
            end
         end

         assign xfer_v_o    = fall & (wide_i | phase_q);
         assign xfer_byte_o = wide_i ? db_i : {hi_q, db_i[BUS_W-1 -: NIB_W]};
         assign phase_o     = phase_q;

         assert_phase_clear_wide_R9 : assert property (@(posedge clk) disable iff (!rst_n)
            wide_i |-> !phase_q);
         assert_first_nibble_R9 : assert property (@(posedge clk) disable iff (!rst_n)
            (fall && !wide_i && !phase_q) |=> phase_q);
      end else begin : g_wide_only
         logic unused_wide;
         assign unused_wide = wide_i;
         assign xfer_v_o    = fall;
         assign xfer_byte_o = db_i;
         assign phase_o     = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/charlcd_busy.sv
module charlcd_busy #(
   parameter int unsigned BUSY_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic busy_o
);

   localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(BUSY_CYCLES);

   generate
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("BUSY_CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= CNT_INIT;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = cnt_q != '0;

   assert_busy_rise_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(load_i));
   assert_busy_after_load_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> busy_o);

endmodule

// File: rtl/charlcd_store.sv
module charlcd_store
   import charlcd_pkg::*;
#(
   parameter int unsigned ADDR_W    = 7,
   parameter bit          NARROW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_v_i,
   input  lcd_op_e           xfer_op_i,
   input  logic [BUS_W-1:0]  xfer_byte_i,
   input  logic              busy_i,
   output logic [ADDR_W-1:0] ac_o,
   output logic [BUS_W-1:0]  dr_o,
   output logic              wide_o,
   output logic              wr_accept_o
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [BUS_W-1:0]  mem [DEPTH];
   logic [ADDR_W-1:0] ac_q, ac_nx, set_a;
   logic              up_q, wide_q;
   logic [BUS_W-1:0]  dr_q;
   logic              go, do_iw, do_dw, do_dr;

   assign go    = xfer_v_i & ~busy_i;
   assign do_iw = go & (xfer_op_i == OP_INSTR_WR);
   assign do_dw = go & (xfer_op_i == OP_DATA_WR);
   assign do_dr = go & (xfer_op_i == OP_DATA_RD);
   assign ac_nx = up_q ? ac_q + 1'b1 : ac_q - 1'b1;
   assign set_a = xfer_byte_i[ADDR_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
      end else if (do_dw) begin
         mem[ac_q] <= xfer_byte_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ac_q   <= '0;
         dr_q   <= '0;
         up_q   <= 1'b1;
         wide_q <= 1'b1;
      end else if (do_iw) begin
         if (is_set_addr(xfer_byte_i)) begin
            ac_q <= set_a;
            dr_q <= mem[set_a];
         end else if (is_width_set(xfer_byte_i)) begin
            wide_q <= xfer_byte_i[4] | ~NARROW_EN;
         end else if (is_step_set(xfer_byte_i)) begin
            up_q <= xfer_byte_i[1];
         end
      end else if (do_dw || do_dr) begin
         ac_q <= ac_nx;
         dr_q <= mem[ac_nx];
      end
   end

   assign ac_o        = ac_q;
   assign dr_o        = dr_q;
   assign wide_o      = wide_q;
   assign wr_accept_o = do_iw | do_dw;

   assert_step_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_v_i && !busy_i && xfer_op_i == OP_DATA_RD) |=>
         ac_q == ($past(up_q) ? $past(ac_q) + 1'b1 : $past(ac_q) - 1'b1));
   assert_status_quiet_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_v_i && xfer_op_i == OP_STATUS_RD) |=> ($stable(ac_q) && $stable(dr_q)));
   assert_busy_drop_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_v_i && busy_i && xfer_op_i != OP_STATUS_RD) |=>
         ($stable(ac_q) && $stable(dr_q) && $stable(wide_q) && $stable(up_q)));

endmodule

// File: rtl/charlcd_host_port.sv
module charlcd_host_port
   import charlcd_pkg::*;
#(
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned BUSY_CYCLES = 8,
   parameter bit          NARROW_EN   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       rs_i,
   input  logic       rw_i,
   input  logic [7:0] db_i,
   output logic [7:0] db_o,
   output logic       db_oe_o
);

   generate
      if (ADDR_W < 1 || ADDR_W > STAT_AW) begin : g_bad_aw
         $error("ADDR_W must lie in 1..7");
      end
   endgenerate

   logic              xfer_v, phase, wide, busy, wr_accept;
   lcd_op_e           xfer_op;
   logic [BUS_W-1:0]  xfer_byte, dr, status_b, sel_b;
   logic [ADDR_W-1:0] ac;
   logic [STAT_AW-1:0] ac_ext;

   charlcd_strobe #(.NARROW_EN(NARROW_EN)) u_strobe (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .rs_i(rs_i), .rw_i(rw_i),
      .db_i(db_i), .wide_i(wide), .xfer_v_o(xfer_v), .xfer_op_o(xfer_op),
      .xfer_byte_o(xfer_byte), .phase_o(phase)
   );

   charlcd_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
      .clk(clk), .rst_n(rst_n), .load_i(wr_accept), .busy_o(busy)
   );

   charlcd_store #(.ADDR_W(ADDR_W), .NARROW_EN(NARROW_EN)) u_store (
      .clk(clk), .rst_n(rst_n), .xfer_v_i(xfer_v), .xfer_op_i(xfer_op),
      .xfer_byte_i(xfer_byte), .busy_i(busy), .ac_o(ac), .dr_o(dr),
      .wide_o(wide), .wr_accept_o(wr_accept)
   );

   assign ac_ext   = STAT_AW'(ac);
   assign status_b = {busy, ac_ext};
   assign sel_b    = rs_i ? dr : status_b;

   always_comb begin
      if (wide) db_o = sel_b;
      else      db_o = {(phase ? sel_b[NIB_W-1:0] : sel_b[BUS_W-1 -: NIB_W]), {NIB_W{1'b0}}};
   end

   assign db_oe_o = en_i & rw_i;

endmodule

// File: tb/charlcd_host_port_bench.sv
module charlcd_host_port_bench;

   localparam int PERIOD = 10;
   localparam int BUSYC  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_i = 1'b0, rs_i = 1'b0, rw_i = 1'b0;
   logic [7:0] db_i = '0;
   logic [7:0] db_o;
   logic       db_oe_o;

   int checks = 0, errors = 0;
   bit done = 0;

   typedef struct { logic [7:0] v; string tag; } item_t;
   item_t exp_q[$];
   logic [7:0] act_q[$];

   always #(PERIOD/2) clk = ~clk;

   charlcd_host_port #(.ADDR_W(7), .BUSY_CYCLES(BUSYC), .NARROW_EN(1'b1)) u_charlcd_host_port (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .rs_i(rs_i), .rw_i(rw_i),
      .db_i(db_i), .db_o(db_o), .db_oe_o(db_oe_o)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (exp_q.size() > 0 && act_q.size() > 0) begin
         item_t e;
         logic [7:0] a;
         e = exp_q.pop_front();
         a = act_q.pop_front();
         chk(e.tag, a, e.v);
      end
   end

   // one strobe; got is the bus value sampled while enable is high
   task automatic xfer(input logic rs, input logic rw, input logic [7:0] d, output logic [7:0] got);
      @(negedge clk);
      rs_i = rs; rw_i = rw; db_i = d; en_i = 1'b1;
      @(negedge clk);
      got = db_o;
      chk("R12 oe during strobe", {7'd0, db_oe_o}, {7'd0, rw});
      en_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic settle();
      repeat (BUSYC + 1) @(negedge clk);
   endtask

   task automatic wr(input logic rs, input logic [7:0] d);
      logic [7:0] g;
      xfer(rs, 1'b0, d, g);
      settle();
   endtask

   task automatic rd(input logic rs, input logic [7:0] exp, input string tag);
      logic [7:0] g;
      exp_q.push_back('{exp, tag});
      xfer(rs, 1'b1, 8'h00, g);
      act_q.push_back(g);
   endtask

   task automatic nwr(input logic rs, input logic [7:0] d);
      logic [7:0] g;
      xfer(rs, 1'b0, {d[7:4], 4'h0}, g);
      xfer(rs, 1'b0, {d[3:0], 4'h0}, g);
      settle();
   endtask

   task automatic nrd(input logic rs, input logic [7:0] exp, input string tag);
      logic [7:0] g;
      exp_q.push_back('{{exp[7:4], 4'h0}, tag});
      exp_q.push_back('{{exp[3:0], 4'h0}, tag});
      xfer(rs, 1'b1, 8'h00, g);
      act_q.push_back(g);
      xfer(rs, 1'b1, 8'h00, g);
      act_q.push_back(g);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] g;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 oe idle", {7'd0, db_oe_o}, 8'h00);
      rd(1'b0, 8'h00, "R1 reset status");

      // R4 set address, R3 status layout
      wr(1'b0, 8'h90);
      rd(1'b0, 8'h10, "R4 set address");

      // R5 writes
      wr(1'b1, 8'hA1); wr(1'b1, 8'hB2); wr(1'b1, 8'hC3);
      rd(1'b0, 8'h13, "R5 counter after writes");

      // R6 reads with prefetch
      wr(1'b0, 8'h90);
      rd(1'b1, 8'hA1, "R6 read 0"); rd(1'b1, 8'hB2, "R6 read 1"); rd(1'b1, 8'hC3, "R6 read 2");
      rd(1'b0, 8'h13, "R6 counter after reads");

      // R3 instruction register not returned
      wr(1'b0, 8'h06);
      rd(1'b0, 8'h13, "R3 status not instruction");

      // R7 downward stepping
      wr(1'b0, 8'h04);
      wr(1'b0, 8'h92);
      rd(1'b1, 8'hC3, "R7 down read 0"); rd(1'b1, 8'hB2, "R7 down read 1");
      rd(1'b0, 8'h10, "R7 down counter");

      // R7 wrap upward
      wr(1'b0, 8'h06);
      wr(1'b0, 8'hFF);
      wr(1'b1, 8'h5A);
      rd(1'b0, 8'h00, "R7 wrap up");
      wr(1'b0, 8'hFF);
      rd(1'b1, 8'h5A, "R5 byte at 7F");

      // R7 wrap downward
      wr(1'b0, 8'h04);
      wr(1'b0, 8'h80);
      wr(1'b1, 8'h33);
      rd(1'b0, 8'h7F, "R7 wrap down");
      wr(1'b0, 8'h06);

      // R2 data taken at the falling edge
      wr(1'b0, 8'hC0);
      @(negedge clk);
      rs_i = 1'b1; rw_i = 1'b0; db_i = 8'h44; en_i = 1'b1;
      repeat (3) @(negedge clk);
      db_i = 8'h55;
      @(negedge clk);
      en_i = 1'b0;
      @(negedge clk);
      settle();
      wr(1'b0, 8'hC0);
      rd(1'b1, 8'h55, "R2 latched at fall");

      // R10 busy window
      wr(1'b0, 8'hA0);
      xfer(1'b1, 1'b0, 8'h77, g);
      @(negedge clk);
      rd(1'b0, 8'hA1, "R10 busy at edge 3");
      settle();
      xfer(1'b1, 1'b0, 8'h78, g);
      repeat (2) @(negedge clk);
      rd(1'b0, 8'h22, "R10 clear at edge 4");
      settle();

      // R11 writes ignored while busy
      xfer(1'b1, 1'b0, 8'h11, g);
      xfer(1'b1, 1'b0, 8'h99, g);
      settle();
      rd(1'b0, 8'h23, "R11 second write dropped");
      wr(1'b0, 8'hA2);
      rd(1'b1, 8'h11, "R11 stored byte");
      wr(1'b0, 8'hA3);
      xfer(1'b1, 1'b0, 8'h66, g);
      xfer(1'b0, 1'b0, 8'h85, g);
      settle();
      rd(1'b0, 8'h24, "R11 instruction dropped");
      wr(1'b0, 8'hA3);
      xfer(1'b1, 1'b0, 8'h67, g);
      xfer(1'b1, 1'b1, 8'h00, g);
      settle();
      rd(1'b0, 8'h24, "R11 read dropped");

      // R8 / R9 four-bit mode
      wr(1'b0, 8'h20);
      nwr(1'b0, 8'h90);
      nrd(1'b0, 8'h10, "R9 status nibbles");
      nrd(1'b1, 8'hA1, "R9 data nibbles");
      nwr(1'b1, 8'hE7);
      nwr(1'b0, 8'h91);
      nrd(1'b1, 8'hE7, "R9 nibble write");
      nwr(1'b0, 8'h30);
      wr(1'b0, 8'h91);
      rd(1'b1, 8'hE7, "R8 back to 8-bit");

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0 || act_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard residue actual=%0d expected=%0d", act_q.size(), exp_q.size());
      end
      finish_run();
   end

endmodule